// File: doc/BRIEF.md
# Five-Source Fixed-Priority Vectored Interrupt Controller

The controller collects five interrupt sources and presents the CPU with one request line and the vector address of the most urgent pending source. The five sources are two external active-low pins, two timer overflow strobes and a serial port whose request is the OR of its receive and transmit flags. An 8-bit enable register holds a per-source mask and a global mask bit. Each external pin passes through a two-stage synchroniser. A per-pin type input selects how the pin is read: as a falling edge that is latched, or as a low level that is followed directly.

The CPU acknowledges by raising `irq_ack`. On the rising edge of that acknowledge the controller latches the vector and marks a service routine as active. It also clears the latched flag of the taken source when that source is a timer or an edge-mode pin. The vector stays frozen and no new request is raised until `svc_done` arrives while the acknowledge is low. The serial flags belong to the serial block and are cleared there by software, so the controller never clears them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 8'h00 and `irq_req` is low.
- R2: A write with `en_we` stores all 8 bits of `en_wd`, and every bit reads back unchanged on `en_q`. Bit 6 and bit 5 never cause a request.
- R3: While enable bit 7 (global) is 0, `irq_req` stays low whatever the sources do.
- R4: Each source needs its own enable bit as well as bit 7. The bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R5: The priority is fixed, highest first: external 0 (vector 16'h0003), timer 0 (16'h000B), external 1 (16'h0013), timer 1 (16'h001B), serial (16'h0023). The vector shown is that of the highest-priority pending enabled source.
- R6: With `ext_edge[n]`=1, a high-to-low transition of `ext_pin_n[n]` latches a flag. The flag keeps requesting after the pin returns high.
- R7: With `ext_edge[n]`=0, the source requests while the synchronised pin is low and stops once the pin is high. An acknowledge leaves nothing latched.
- R8: A one-cycle `tmrN_ovf` pulse latches a timer flag. On an acknowledge, the flag of the taken timer or edge-mode source is cleared.
- R9: The serial source requests while `ser_rx` or `ser_tx` is high. An acknowledge does not clear it.
- R10: A request is taken on the rising edge of `irq_ack` while `irq_req` is high. From the next cycle the vector is held stable and `irq_req` stays low while the routine is active, even if new sources become pending.
- R11: `svc_done`, sampled while `irq_ack` is low, ends the active state. Any pending source then raises `irq_req` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Enable register write strobe |
| en_wd | input | 8 | Enable register write data |
| en_q | output | 8 | Enable register contents |
| ext_edge | input | 2 | Per-pin type: 1 falling edge, 0 low level |
| ext_pin_n | input | 2 | External active-low request pins |
| tmr0_ovf | input | 1 | Timer 0 overflow strobe |
| tmr1_ovf | input | 1 | Timer 1 overflow strobe |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec | output | VW | Vector address |
| irq_ack | input | 1 | CPU acknowledge |
| svc_done | input | 1 | End of service routine |

## Verification
The bench uses the default parameters: a 16-bit vector, a base of 3, a step of 8 and a two-stage synchroniser. With these values the five vectors fall on the expected addresses, and every pin event needs three clock edges before it reaches a flag. A table of masked and unmasked source combinations covers the priority order and the global and per-source masks. Directed sequences then check the edge and level capture, clear-on-acknowledge, the serial flag that persists, and the vector freeze while a new timer event arrives during service.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VW     = 16,
  parameter int SYNC_N = 2,
  parameter int VBASE  = 3,
  parameter int VSTEP  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_we,
  input  logic [7:0]    en_wd,
  output logic [7:0]    en_q,
  input  logic [1:0]    ext_edge,
  input  logic [1:0]    ext_pin_n,
  input  logic          tmr0_ovf,
  input  logic          tmr1_ovf,
  input  logic          ser_rx,
  input  logic          ser_tx,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  input  logic          irq_ack,
  input  logic          svc_done
);
  localparam int NSRC = 5;
  localparam int PW   = $clog2(NSRC);

  logic [SYNC_N-1:0] sync [2];
  logic [1:0]        last, xflag, xreq;
  logic              tf0, tf1, ack_d, active, hit, take;
  logic [NSRC-1:0]   pend;
  logic [PW-1:0]     pick;
  logic [VW-1:0]     enc, held;

  always_ff @(posedge clk)
    if (!rst_n) en_q <= '0;
    else if (en_we) en_q <= en_wd;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    logic smp, fall;
    assign smp  = sync[g][SYNC_N-1];
    assign fall = last[g] & ~smp;
    always_ff @(posedge clk)
      if (!rst_n) begin
        sync[g]  <= '1;
        last[g]  <= 1'b1;
        xflag[g] <= 1'b0;
      end else begin
        sync[g] <= {sync[g][SYNC_N-2:0], ext_pin_n[g]};
        last[g] <= smp;
        if (!ext_edge[g]) xflag[g] <= 1'b0;
        else if (fall) xflag[g] <= 1'b1;
        else if (take && pick == PW'(2*g)) xflag[g] <= 1'b0;
      end
    assign xreq[g] = ext_edge[g] ? xflag[g] : ~smp;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      tf0 <= 1'b0;
      tf1 <= 1'b0;
    end else begin
      if (tmr0_ovf) tf0 <= 1'b1;
      else if (take && pick == PW'(1)) tf0 <= 1'b0;
      if (tmr1_ovf) tf1 <= 1'b1;
      else if (take && pick == PW'(3)) tf1 <= 1'b0;
    end

  assign pend = {ser_rx | ser_tx, tf1, xreq[1], tf0, xreq[0]}
              & en_q[NSRC-1:0] & {NSRC{en_q[7]}};
  assign hit  = |pend;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) pick = PW'(i);
  end

  assign enc     = hit ? VW'(VBASE + VSTEP * int'(pick)) : '0;
  assign irq_req = hit & ~active;
  assign take    = irq_req & irq_ack & ~ack_d;
  assign irq_vec = active ? held : enc;

  always_ff @(posedge clk)
    if (!rst_n) begin
      ack_d  <= 1'b0;
      active <= 1'b0;
      held   <= '0;
    end else begin
      ack_d <= irq_ack;
      if (take) begin
        active <= 1'b1;
        held   <= enc;
      end else if (svc_done && !irq_ack) active <= 1'b0;
    end

  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[7] |-> !irq_req); // R3
  AST_QUIET_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !irq_req); // R10
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(irq_vec)); // R10
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3)); // R5
  AST_T0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pick == PW'(1) && !tmr0_ovf) |=> !tf0); // R8
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[4:0] == 5'd0) |-> !irq_req); // R2
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_we = 0; logic [7:0] en_wd = 0; logic [7:0] en_q;
  logic [1:0] ext_edge = 0, ext_pin_n = 2'b11;
  logic tmr0_ovf = 0, tmr1_ovf = 0, ser_rx = 0, ser_tx = 0;
  logic irq_req; logic [15:0] irq_vec;
  logic irq_ack = 0, svc_done = 0;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (.clk, .rst_n, .en_we, .en_wd, .en_q, .ext_edge, .ext_pin_n,
    .tmr0_ovf, .tmr1_ovf, .ser_rx, .ser_tx, .irq_req, .irq_vec, .irq_ack, .svc_done);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {en[22:15], x0low, x1low, t0, t1, rx, tx, exp_req, exp_vec[7:0]}
  localparam logic [22:0] TBL [11] = '{
    {8'h9F, 6'b111111, 1'b1, 8'h03},   // R5
    {8'h9F, 6'b001110, 1'b1, 8'h0B},   // R5
    {8'h9F, 6'b010100, 1'b1, 8'h13},   // R5
    {8'h9F, 6'b000110, 1'b1, 8'h1B},   // R5
    {8'h9F, 6'b000010, 1'b1, 8'h23},   // R9 rx
    {8'h9F, 6'b000001, 1'b1, 8'h23},   // R9 tx
    {8'h1F, 6'b111111, 1'b0, 8'h00},   // R3
    {8'h9E, 6'b101000, 1'b1, 8'h0B},   // R4
    {8'hE0, 6'b111111, 1'b0, 8'h00},   // R2 R4
    {8'h90, 6'b001100, 1'b0, 8'h00},   // R4
    {8'h88, 6'b010100, 1'b1, 8'h1B}    // R4
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; ext_pin_n = 2'b11; tmr0_ovf = 0; tmr1_ovf = 0;
    ser_rx = 0; ser_tx = 0; irq_ack = 0; svc_done = 0;
    tick(2); rst_n = 1; tick(1);
  endtask

  task automatic wr_en(logic [7:0] v);
    en_we = 1; en_wd = v; tick(1); en_we = 0;
  endtask

  task automatic ack_done();
    irq_ack = 1; tick(1); irq_ack = 0; tick(1);
    svc_done = 1; tick(1); svc_done = 0; tick(1);
  endtask

  initial begin
    tick(1);
    do_reset();
    chk("R1 en", en_q, 8'h00);
    chk("R1 req", irq_req, 0);

    for (int i = 0; i < 11; i++) begin
      do_reset();
      ext_edge = 2'b00;
      wr_en(TBL[i][22:15]);
      ext_pin_n = ~{TBL[i][13], TBL[i][14]};
      tmr0_ovf = TBL[i][12]; tmr1_ovf = TBL[i][11];
      ser_rx = TBL[i][10]; ser_tx = TBL[i][9];
      tick(1); tmr0_ovf = 0; tmr1_ovf = 0;
      tick(4);
      chk($sformatf("R5 row%0d req", i), irq_req, TBL[i][8]);
      if (TBL[i][8]) chk($sformatf("R5 row%0d vec", i), irq_vec, TBL[i][7:0]);
    end

    do_reset();
    wr_en(8'h65);
    chk("R2 readback", en_q, 8'h65);
    chk("R2 rsvd req", irq_req, 0);

    // R6 / R8 edge capture and clear on ack
    do_reset(); ext_edge = 2'b01; wr_en(8'h81);
    ext_pin_n[0] = 0; tick(5); ext_pin_n[0] = 1; tick(5);
    chk("R6 latched req", irq_req, 1);
    chk("R6 vec", irq_vec, 16'h0003);
    irq_ack = 1; tick(2);
    chk("R10 req low in svc", irq_req, 0);
    chk("R10 vec held", irq_vec, 16'h0003);
    irq_ack = 0; tick(1); svc_done = 1; tick(1); svc_done = 0; tick(1);
    chk("R8 edge flag cleared", irq_req, 0);

    // R7 level mode
    do_reset(); ext_edge = 2'b00; wr_en(8'h84);
    ext_pin_n[1] = 0; tick(4);
    chk("R7 level req", irq_req, 1);
    chk("R7 level vec", irq_vec, 16'h0013);
    ack_done();
    chk("R7 still low re-req", irq_req, 1);
    ext_pin_n[1] = 1; tick(4);
    chk("R7 release", irq_req, 0);

    // R9 serial not cleared by ack
    do_reset(); wr_en(8'h90);
    ser_rx = 1; tick(1);
    ack_done();
    chk("R9 serial persists", irq_req, 1);
    chk("R9 vec", irq_vec, 16'h0023);
    ser_rx = 0; tick(1);
    chk("R9 sw clear", irq_req, 0);

    // R10 / R11 / R8 timer during service
    do_reset(); wr_en(8'h8A);
    tmr0_ovf = 1; tick(1); tmr0_ovf = 0; tick(1);
    chk("R8 t0 vec", irq_vec, 16'h000B);
    irq_ack = 1; tick(1);
    tmr1_ovf = 1; tick(1); tmr1_ovf = 0; tick(1);
    chk("R10 hold during new src", irq_vec, 16'h000B);
    chk("R10 no req", irq_req, 0);
    irq_ack = 0; tick(1);
    svc_done = 1; irq_ack = 0; tick(1); svc_done = 0; tick(1);
    chk("R11 re-req", irq_req, 1);
    chk("R11 t1 vec (t0 cleared R8)", irq_vec, 16'h001B);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule